// File: doc/BRIEF.md
# In-Order Instruction Completion Queue

This block keeps every dispatched instruction in a sixteen-entry circular queue, in program order. It retires instructions from the head of the queue, up to three in one clock. An instruction retires only after it has finished, only if it carries no exception, and only after all older instructions have left the queue. Because of this ordering, exceptions stay precise. It also keeps the younger part of the queue consistent when a branch turns out to be mispredicted.

Dispatch asks for up to three consecutive entries per cycle. It gets them all or none of them, and each granted slot's entry tag comes back on the same cycle. Execution units report completion by tag, with an exception flag. The branch unit reports resolution by tag, with a mispredict flag. The block drives three things:

- a retire count and the retiring tags;
- a squash signal naming the mispredicted branch, when younger entries are discarded;
- an exception signal naming the head entry, when the whole queue is discarded.

All outputs are combinational functions of the stored state and the current inputs. The state itself changes at the rising clock edge.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty. `allocGrant` is 1, `allocTags` slots 0, 1 and 2 hold tags 0, 1 and 2, and `retireCount`, `excRaise` and `squashYoung` are 0.
- R2: Allocation is all or nothing.
  - A request of `allocCount` entries (0 to 3) is refused when the occupancy at the start of the cycle plus the request exceeds 16. Entries retiring in that cycle are not credited.
  - Slot k of `allocTags` (bits 4k+3:4k) carries (tail + k) mod 16, where tail is the next free index.
  - A granted request occupies those entries in slot order.
- R3: `retireCount` equals the number of leading entries, counted from the head, that are occupied, finished and free of an exception flag, capped at 3. Slot k of `retireTags` (bits 4k+3:4k) carries (head + k) mod 16.
- R4: A finished entry never retires while an older entry is still unfinished or flagged. Retirement is strictly in program order.
- R5: When the head entry has finished with its exception flag set, the following hold in that cycle:
  - `excRaise` is 1 and `excTag` gives the head tag;
  - `retireCount` is 0 and `allocGrant` is 0.
  At the next edge every entry is discarded, and the next allocation starts at that same head index.
- R6: A resolve report for an occupied, unresolved branch entry marks that entry finished, whether or not it was mispredicted. A branch entry can then retire without any finish report.
- R7: A mispredict report for an occupied, unresolved branch has these effects, provided R5 is not active in that cycle:
  - `squashYoung` is 1 and `squashTag` equals the branch tag in the same cycle;
  - allocation is refused that cycle, while older entries still retire;
  - all entries younger than the branch are discarded at the edge;
  - the next allocation starts at branch tag + 1.
- R8: Bit k of `allocBranch` marks slot k of the request as a branch. A request is refused if it would bring the number of occupied unresolved branches above 3.
- R9: A finish report naming an unoccupied tag has no effect. A resolve report naming an entry that is not an unresolved branch has no effect: it raises no squash and does not finish the entry.
- R10: Allocation and retirement in the same cycle both take effect. The occupancy changes by their difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocCount | input | 2 | Number of entries requested by dispatch this cycle |
| allocBranch | input | 3 | Per-slot flag: the requested instruction is a branch |
| allocGrant | output | 1 | Whole request accepted this cycle |
| allocTags | output | 12 | Tags for request slots 0..2, four bits each |
| finValid | input | 1 | Finish report present |
| finTag | input | 4 | Tag of the finished entry |
| finExc | input | 1 | Finished entry carries an exception |
| brValid | input | 1 | Branch resolve report present |
| brTag | input | 4 | Tag of the resolved branch |
| brMispred | input | 1 | Resolved branch was mispredicted |
| retireCount | output | 2 | Entries retired this cycle |
| retireTags | output | 12 | Tags of retire slots 0..2, four bits each |
| excRaise | output | 1 | Head entry excepts; whole queue discarded |
| excTag | output | 4 | Tag of the excepting entry |
| squashYoung | output | 1 | Entries younger than `squashTag` discarded |
| squashTag | output | 4 | Tag of the mispredicted branch |

## Verification
The bench goes after these corner cases, each with the failure it would expose:

- **Queue full.** A request for more entries than remain must be refused. A design that credited same-cycle retirement would grant one too many and overwrite the head.
- **Fourth unresolved branch.** This request must be refused. A wrong branch counter would admit it.
- **Finished entry behind an unfinished one.** A design that retired any finished entry would lose program order. This shows up as a wrong retire count or wrong tags.
- **Mispredict while older entries retire.** This checks that the kept count excludes the retiring entries. An error here would shift every later tag.
- **Exception at the head.** A wrong design would retire the faulting entry or fail to restart allocation at its index.
- **Stray reports.** Resolve reports aimed at non-branch entries must neither squash nor finish them.

Long pseudo-random stretches wrap both pointers many times, including mispredicts on branches sitting at index 15.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam int RQ_DEPTH  = 16;
  localparam int RQ_SLOTS  = 3;
  localparam int RQ_MAX_BR = 3;
  localparam int RQ_TAG_W  = $clog2(RQ_DEPTH);
  localparam int RQ_CNT_W  = RQ_TAG_W + 1;
  localparam int RQ_NUM_W  = $clog2(RQ_SLOTS + 1);

  typedef logic [RQ_TAG_W-1:0] rqTag_t;

  // control decisions passed from rq_ctrl to rq_entries
  typedef struct packed {
    logic [RQ_SLOTS-1:0] allocEn;
    logic [RQ_SLOTS-1:0] allocBr;
    rqTag_t              tail;
    logic [RQ_NUM_W-1:0] retireN;
    rqTag_t              head;
    logic                squash;
    rqTag_t              squashTag;
    logic                clearAll;
  } rqStrobe_t;
endpackage

// File: rtl/rq_entries.sv
module rq_entries
  import rq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rqStrobe_t           strobe,
  input  logic                finValid,
  input  rqTag_t              finTag,
  input  logic                finExc,
  input  logic                brValid,
  input  rqTag_t              brTag,
  output logic [RQ_DEPTH-1:0] entValid,
  output logic [RQ_DEPTH-1:0] entDone,
  output logic [RQ_DEPTH-1:0] entExc,
  output logic [RQ_DEPTH-1:0] entPend
);
  logic [RQ_DEPTH-1:0] younger, retHit, allocHit, allocIsBr;

  always_comb begin
    for (int i = 0; i < RQ_DEPTH; i++) begin
      // distance from head decides age, independent of wrap
      younger[i] = strobe.squash &&
                   ((rqTag_t'(i) - strobe.head) > (strobe.squashTag - strobe.head));
      retHit[i]  = int'(rqTag_t'(rqTag_t'(i) - strobe.head)) < int'(strobe.retireN);
      allocHit[i]  = 1'b0;
      allocIsBr[i] = 1'b0;
      for (int k = 0; k < RQ_SLOTS; k++) begin
        if (strobe.allocEn[k] && (rqTag_t'(strobe.tail + rqTag_t'(k)) == rqTag_t'(i))) begin
          allocHit[i]  = 1'b1;
          allocIsBr[i] = strobe.allocBr[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entDone  <= '0;
      entExc   <= '0;
      entPend  <= '0;
    end else begin
      for (int i = 0; i < RQ_DEPTH; i++) begin
        if (strobe.clearAll || younger[i] || retHit[i]) begin
          entValid[i] <= 1'b0;
        end else if (allocHit[i]) begin
          entValid[i] <= 1'b1;
          entDone[i]  <= 1'b0;
          entExc[i]   <= 1'b0;
          entPend[i]  <= allocIsBr[i];
        end else if (entValid[i]) begin
          if (finValid && (finTag == rqTag_t'(i))) begin
            entDone[i] <= 1'b1;
            entExc[i]  <= finExc;
          end
          if (brValid && (brTag == rqTag_t'(i)) && entPend[i]) begin
            entDone[i] <= 1'b1;
            entPend[i] <= 1'b0;
          end
        end
      end
    end
  end

  // R2: a granted slot always lands on a free entry
  a_r2_alloc_into_free: assert property (@(posedge clk) disable iff (!rstN)
    (allocHit & entValid) == '0);
endmodule

// File: rtl/rq_ctrl.sv
module rq_ctrl
  import rq_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [RQ_NUM_W-1:0]          allocCount,
  input  logic [RQ_SLOTS-1:0]          allocBranch,
  input  logic                         brValid,
  input  rqTag_t                       brTag,
  input  logic                         brMispred,
  input  logic [RQ_DEPTH-1:0]          entValid,
  input  logic [RQ_DEPTH-1:0]          entDone,
  input  logic [RQ_DEPTH-1:0]          entExc,
  input  logic [RQ_DEPTH-1:0]          entPend,
  output logic                         allocGrant,
  output logic [RQ_SLOTS*RQ_TAG_W-1:0] allocTags,
  output logic [RQ_NUM_W-1:0]          retireCount,
  output logic [RQ_SLOTS*RQ_TAG_W-1:0] retireTags,
  output logic                         excRaise,
  output rqTag_t                       excTag,
  output logic                         squashYoung,
  output rqTag_t                       squashTag,
  output rqStrobe_t                    strobe
);
  rqTag_t              headQ, tailQ;
  logic [RQ_CNT_W-1:0] cntQ, keepCnt;
  logic [RQ_NUM_W-1:0] retN, allocN;
  logic [RQ_SLOTS-1:0] reqMask;
  int                  unres, brReq;
  logic                fits, branchOk;

  always_comb begin : retire_scan
    logic   stop;
    rqTag_t idx;
    retN = '0;
    stop = 1'b0;
    for (int k = 0; k < RQ_SLOTS; k++) begin
      idx = headQ + rqTag_t'(k);
      if (!stop && (RQ_CNT_W'(k) < cntQ) && entDone[idx] && !entExc[idx])
        retN = retN + RQ_NUM_W'(1);
      else
        stop = 1'b1;
    end
  end

  always_comb begin
    for (int k = 0; k < RQ_SLOTS; k++) reqMask[k] = RQ_NUM_W'(k) < allocCount;
  end

  assign excRaise    = (cntQ != '0) && entDone[headQ] && entExc[headQ];
  assign excTag      = headQ;
  assign squashYoung = brValid && brMispred && entValid[brTag] && entPend[brTag] && !excRaise;
  assign squashTag   = brTag;
  assign unres       = $countones(entValid & entPend);
  assign brReq       = $countones(allocBranch & reqMask);
  assign fits        = (int'(cntQ) + int'(allocCount)) <= RQ_DEPTH;
  assign branchOk    = (unres + brReq) <= RQ_MAX_BR;
  assign allocGrant  = fits && branchOk && !excRaise && !squashYoung;
  assign allocN      = allocGrant ? allocCount : '0;
  assign retireCount = retN;
  assign keepCnt     = {1'b0, rqTag_t'(brTag - headQ)} + RQ_CNT_W'(1);

  generate
    for (genvar g = 0; g < RQ_SLOTS; g++) begin : g_slot
      assign allocTags[g*RQ_TAG_W +: RQ_TAG_W]  = tailQ + rqTag_t'(g);
      assign retireTags[g*RQ_TAG_W +: RQ_TAG_W] = headQ + rqTag_t'(g);
    end
  endgenerate

  always_comb begin
    strobe.allocEn   = allocGrant ? reqMask : '0;
    strobe.allocBr   = allocBranch;
    strobe.tail      = tailQ;
    strobe.retireN   = retN;
    strobe.head      = headQ;
    strobe.squash    = squashYoung;
    strobe.squashTag = brTag;
    strobe.clearAll  = excRaise;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      cntQ  <= '0;
    end else if (excRaise) begin
      tailQ <= headQ;
      cntQ  <= '0;
    end else begin
      headQ <= headQ + rqTag_t'(retN);
      if (squashYoung) begin
        tailQ <= brTag + rqTag_t'(1);
        cntQ  <= keepCnt - RQ_CNT_W'(retN);
      end else begin
        tailQ <= tailQ + rqTag_t'(allocN);
        cntQ  <= cntQ + RQ_CNT_W'(allocN) - RQ_CNT_W'(retN);
      end
    end
  end

  // R2: occupancy never exceeds the queue depth
  a_r2_occupancy_bound: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= RQ_CNT_W'(RQ_DEPTH));
  // R8: unresolved branch limit
  a_r8_branch_cap: assert property (@(posedge clk) disable iff (!rstN)
    unres <= RQ_MAX_BR);
  // R3: a retiring head entry is really present and finished
  a_r3_head_ready: assert property (@(posedge clk) disable iff (!rstN)
    (retireCount != '0) |-> (entValid[headQ] && entDone[headQ]));
  // R5: exception blocks retirement and allocation
  a_r5_exc_blocks: assert property (@(posedge clk) disable iff (!rstN)
    excRaise |-> ((retireCount == '0) && !allocGrant));
  // R5: every entry is gone after an exception
  a_r5_exc_empties: assert property (@(posedge clk) disable iff (!rstN)
    excRaise |=> ((cntQ == '0) && (entValid == '0)));
  // R7: tail restarts just past the mispredicted branch
  a_r7_squash_tail: assert property (@(posedge clk) disable iff (!rstN)
    squashYoung |=> (tailQ == rqTag_t'($past(brTag) + rqTag_t'(1))));
  // R10: the net count agrees with the occupied entries
  a_r10_occupancy_tracks: assert property (@(posedge clk) disable iff (!rstN)
    int'(cntQ) == $countones(entValid));
endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import rq_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [RQ_NUM_W-1:0]          allocCount,
  input  logic [RQ_SLOTS-1:0]          allocBranch,
  output logic                         allocGrant,
  output logic [RQ_SLOTS*RQ_TAG_W-1:0] allocTags,
  input  logic                         finValid,
  input  logic [RQ_TAG_W-1:0]          finTag,
  input  logic                         finExc,
  input  logic                         brValid,
  input  logic [RQ_TAG_W-1:0]          brTag,
  input  logic                         brMispred,
  output logic [RQ_NUM_W-1:0]          retireCount,
  output logic [RQ_SLOTS*RQ_TAG_W-1:0] retireTags,
  output logic                         excRaise,
  output logic [RQ_TAG_W-1:0]          excTag,
  output logic                         squashYoung,
  output logic [RQ_TAG_W-1:0]          squashTag
);
  rqStrobe_t           strobe;
  logic [RQ_DEPTH-1:0] entValid, entDone, entExc, entPend;

  rq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .allocCount(allocCount), .allocBranch(allocBranch),
    .brValid(brValid), .brTag(brTag), .brMispred(brMispred),
    .entValid(entValid), .entDone(entDone), .entExc(entExc), .entPend(entPend),
    .allocGrant(allocGrant), .allocTags(allocTags), .retireCount(retireCount),
    .retireTags(retireTags), .excRaise(excRaise), .excTag(excTag),
    .squashYoung(squashYoung), .squashTag(squashTag), .strobe(strobe)
  );

  rq_entries i_entries (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .finValid(finValid), .finTag(finTag), .finExc(finExc),
    .brValid(brValid), .brTag(brTag),
    .entValid(entValid), .entDone(entDone), .entExc(entExc), .entPend(entPend)
  );
endmodule

// File: tb/test_retire_queue.sv
`timescale 1ns/1ps
module test_retire_queue;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] allocCount = '0;
  logic [2:0] allocBranch = '0;
  logic allocGrant;
  logic [11:0] allocTags;
  logic finValid = 1'b0;
  logic [3:0] finTag = '0;
  logic finExc = 1'b0;
  logic brValid = 1'b0;
  logic [3:0] brTag = '0;
  logic brMispred = 1'b0;
  logic [1:0] retireCount;
  logic [11:0] retireTags;
  logic excRaise;
  logic [3:0] excTag;
  logic squashYoung;
  logic [3:0] squashTag;

  int checks = 0, fails = 0;
  bit finished = 0;
  int mHead = 0, mTail = 0, mCnt = 0;
  bit mV[16], mD[16], mE[16], mP[16];

  always #2 clk = ~clk;

  retire_queue i_retire_queue (
    .clk(clk), .rstN(rstN), .allocCount(allocCount), .allocBranch(allocBranch),
    .allocGrant(allocGrant), .allocTags(allocTags), .finValid(finValid),
    .finTag(finTag), .finExc(finExc), .brValid(brValid), .brTag(brTag),
    .brMispred(brMispred), .retireCount(retireCount), .retireTags(retireTags),
    .excRaise(excRaise), .excTag(excTag), .squashYoung(squashYoung),
    .squashTag(squashTag)
  );

  task automatic expect_eq(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // drive one cycle, compare against the queue model, then advance the model
  task automatic step(input int aN, input int aBr, input bit fV, input int fT,
                      input bit fE, input bit bV, input int bT, input bit bM);
    int eRet, unres, brReq, idx, keep;
    bit eExc, eSq, eGrant, stop;
    @(negedge clk);
    allocCount = 2'(aN); allocBranch = 3'(aBr);
    finValid = fV; finTag = 4'(fT); finExc = fE;
    brValid = bV; brTag = 4'(bT); brMispred = bM;
    #1;
    eExc = mCnt > 0 && mD[mHead] && mE[mHead];
    eRet = 0; stop = 0;
    for (int k = 0; k < 3; k++) begin
      idx = (mHead + k) % 16;
      if (!stop && k < mCnt && mD[idx] && !mE[idx]) eRet++;
      else stop = 1;
    end
    unres = 0;
    for (int i = 0; i < 16; i++) if (mV[i] && mP[i]) unres++;
    brReq = 0;
    for (int k = 0; k < aN; k++) if (((aBr >> k) & 1) == 1) brReq++;
    eSq = bV && bM && mV[bT] && mP[bT] && !eExc;
    eGrant = !eExc && !eSq && (mCnt + aN <= 16) && (unres + brReq <= 3);

    expect_eq("R2 R8 allocGrant", int'(allocGrant), int'(eGrant));
    for (int k = 0; k < 3; k++)
      expect_eq("R2 allocTags slot", int'(allocTags[k*4 +: 4]), (mTail + k) % 16);
    expect_eq("R3 R4 retireCount", int'(retireCount), eRet);
    for (int k = 0; k < eRet; k++)
      expect_eq("R3 retireTags slot", int'(retireTags[k*4 +: 4]), (mHead + k) % 16);
    expect_eq("R5 excRaise", int'(excRaise), int'(eExc));
    if (eExc) expect_eq("R5 excTag", int'(excTag), mHead);
    expect_eq("R7 R9 squashYoung", int'(squashYoung), int'(eSq));
    if (eSq) expect_eq("R7 squashTag", int'(squashTag), bT);

    // model update (R6 resolve finishes the branch, R9 strays ignored)
    if (fV && mV[fT]) begin mD[fT] = 1; mE[fT] = fE; end
    if (bV && mV[bT] && mP[bT]) begin mD[bT] = 1; mP[bT] = 0; end
    if (eExc) begin
      for (int i = 0; i < 16; i++) mV[i] = 0;
      mTail = mHead; mCnt = 0;
    end else begin
      for (int k = 0; k < eRet; k++) mV[(mHead + k) % 16] = 0;
      if (eSq) begin
        keep = ((bT - mHead + 16) % 16) + 1;
        for (int d = keep; d < mCnt; d++) mV[(mHead + d) % 16] = 0;
        mTail = (bT + 1) % 16;
        mCnt = keep - eRet;
      end else begin
        if (eGrant) begin
          for (int k = 0; k < aN; k++) begin
            idx = (mTail + k) % 16;
            mV[idx] = 1; mD[idx] = 0; mE[idx] = 0; mP[idx] = ((aBr >> k) & 1) == 1;
          end
          mTail = (mTail + aN) % 16;
          mCnt = mCnt + aN;
        end
        mCnt = mCnt - eRet;
      end
      mHead = (mHead + eRet) % 16;
    end
  endtask

  task automatic sweep(input int cycles, input int allocMax, input int finPct);
    int aN, aBr, fT, bT, idx;
    bit fV, fE, bV, bM;
    for (int n = 0; n < cycles; n++) begin
      aN = int'($urandom % (allocMax + 1));
      aBr = ($urandom % 3 == 0) ? int'($urandom % 8) : 0;
      fV = 0; fT = 0; fE = 0; bV = 0; bT = 0; bM = 0;
      if (mCnt > 0 && int'($urandom % 100) < finPct) begin
        idx = (mHead + int'($urandom % mCnt)) % 16;
        if (!mP[idx]) begin fV = 1; fT = idx; fE = ($urandom % 30 == 0); end
      end else if ($urandom % 10 == 0) begin
        fV = 1; fT = int'($urandom % 16);
      end
      if (mCnt > 0 && $urandom % 3 == 0) begin
        idx = (mHead + int'($urandom % mCnt)) % 16;
        if (mV[idx] && mP[idx]) begin bV = 1; bT = idx; bM = ($urandom % 3 == 0); end
      end else if ($urandom % 12 == 0) begin
        bV = 1; bT = int'($urandom % 16); bM = 1;
      end
      step(aN, aBr, fV, fT, fE, bV, bT, bM);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset
    step(0, 0, 0, 0, 0, 0, 0, 0);
    expect_eq("R1 allocGrant", int'(allocGrant), 1);
    expect_eq("R1 allocTags", int'(allocTags), 'h210);
    expect_eq("R1 retireCount", int'(retireCount), 0);
    // R8: three branches fill the limit, a fourth is refused
    step(3, 7, 0, 0, 0, 0, 0, 0);
    expect_eq("R8 three branches granted", int'(allocGrant), 1);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    expect_eq("R8 fourth branch refused", int'(allocGrant), 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    expect_eq("R8 plain entry granted", int'(allocGrant), 1);
    // R6 resolve tag0; tag3 finished behind unresolved tag1
    step(0, 0, 1, 3, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    expect_eq("R6 R4 resolved branch retires alone", int'(retireCount), 1);
    // R7 mispredict tag1 squashes tags 2 and 3
    step(2, 0, 0, 0, 0, 1, 1, 1);
    expect_eq("R7 squashYoung", int'(squashYoung), 1);
    expect_eq("R7 allocation refused", int'(allocGrant), 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    expect_eq("R7 restart tag", int'(allocTags[3:0]), 2);
    expect_eq("R7 branch retires", int'(retireCount), 1);
    // R9 resolve aimed at a non-branch entry
    step(0, 0, 0, 0, 0, 1, 2, 1);
    expect_eq("R9 no squash", int'(squashYoung), 0);
    expect_eq("R9 not finished", int'(retireCount), 0);
    // R5 exception at head tag2
    step(0, 0, 1, 2, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    expect_eq("R5 excRaise", int'(excRaise), 1);
    expect_eq("R5 excTag", int'(excTag), 2);
    expect_eq("R5 no retire", int'(retireCount), 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    expect_eq("R5 restart tag", int'(allocTags[3:0]), 2);
    // R10 R2 mixed traffic
    sweep(4000, 3, 50);
    sweep(3000, 1, 90);
    sweep(3000, 3, 80);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule